// File: doc/BRIEF.md
# Performance Monitor Timebase Generator

This block issues a single-cycle `tick_o` pulse that tells performance-monitor counters elsewhere in the chip when to latch. The pulse can come from one of three places. The first is an internal interval counter that runs on the master clock. Its terminal count is programmed so that one interval lasts a millisecond. The second is an external timebase input. The third is a pulse input from an on-board controller. On top of any of these, software can fire one pulse by hand.

Software controls the block through two word-wide registers. Address 0 is the control word. Bit 0 picks the mode: 1 means the automatic sources are used and 0 means the external timebase input is used. Bit 1 picks the automatic source: 1 is the interval counter and 0 is the controller pulse. Bit 2 is the manual trigger and clears itself. Address 1 holds the 18-bit interval length, counted in master-clock cycles. Both external inputs are treated as asynchronous. Each one passes through a two-flop synchronizer and then a rising-edge detector.

Top module: `pmon_timebase`

## Requirements
- R1: While reset is held and in the first cycle after it, `tick_o` is 0, the control word reads 0x3 (bit 0 = 1, bit 1 = 1, bit 2 = 0) and the interval register reads 0x1E600.
- R2: At address 0, bits 0 and 1 are read/write and bits 31..3 read 0. At address 1, bits 17..0 are read/write and bits 31..18 read 0. Any other address reads 0 and ignores writes.
- R3: When control bits 0 and 1 are both 1, `tick_o` pulses for one cycle every max(P,1) cycles, where P is the interval register.
- R4: A new interval value does not cut short the interval in progress; it is used from the next reload. While the interval counter is not selected it holds at max(P,1), so the first interval after it is selected uses the current P.
- R5: An interval value of 0 behaves as 1, so `tick_o` is high on every cycle.
- R6: With control bit 0 = 0, each rising edge of `ext_tb_i` gives exactly one tick. A level that is high at one rising clock edge gives `tick_o` high after the second following edge. A level held high gives no further ticks.
- R7: With control bit 0 = 1 and bit 1 = 0, each rising edge of `obc_pulse_i` gives exactly one tick, with the same latency as R6.
- R8: An input that the current mode does not select has no effect on `tick_o`.
- R9: Writing 1 to control bit 2 gives exactly one tick, in the cycle after the one following the write edge, in every mode. Bit 2 reads 0 again once that tick has been issued.
- R10: A manual trigger and an automatic tick that fall in the same cycle produce a single one-cycle tick, not two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr_i | input | 1 | Register write strobe |
| csr_addr_i | input | ADDR_W (8) | Register address: 0 control, 1 interval |
| csr_wdata_i | input | DATA_W (32) | Register write data |
| csr_rdata_o | output | DATA_W (32) | Register read data for `csr_addr_i`, combinational |
| ext_tb_i | input | 1 | External timebase input, asynchronous |
| obc_pulse_i | input | 1 | On-board controller pulse input, asynchronous |
| tick_o | output | 1 | Single-cycle timebase tick |

## Verification
A manual trigger can land in the same cycle as an automatic tick. The automatic tick may come from the interval counter or from an edge on an external input. To provoke this, the bench runs the interval counter with a short period. It then issues manual writes at four successive phase offsets, so that one of them lines up with the terminal count. The bench's reference model marks the cycles where both causes fall together. It compares `tick_o` on every clock and expects exactly one high cycle there. It also confirms that at least one such overlap took place.

// File: rtl/pmon_tbase_pkg.sv
// Package: shared address map, control-bit positions and source decoding
// for the performance-monitor timebase generator.
package pmon_tbase_pkg;

    // Register addresses (word offsets within the block).
    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_PERIOD = 1;

    // Control word bit positions.
    localparam int CTRL_MODE_BIT = 0;
    localparam int CTRL_SRC_BIT  = 1;
    localparam int CTRL_MAN_BIT  = 2;

    // Which automatic source currently drives the tick.
    typedef enum logic [1:0] {
        SRC_EXT_TB  = 2'd0,
        SRC_INT_TMR = 2'd1,
        SRC_OBC     = 2'd2
    } tb_src_e;

    // Map the two control bits onto the active automatic source.
    function automatic tb_src_e decode_src(input logic mode_auto, input logic src_int);
        if (!mode_auto)
            return SRC_EXT_TB;
        else if (src_int)
            return SRC_INT_TMR;
        else
            return SRC_OBC;
    endfunction

endpackage

// File: rtl/pmon_tbase_csr.sv
// Module: pmon_tbase_csr
// Holds the control word and the interval register.
// The manual-trigger bit is a one-cycle pending flag: it is set by a write
// and cleared on the next clock.
// Assumes DATA_W >= PERIOD_W and DATA_W >= 3, and that reads are combinational.
module pmon_tbase_csr
    import pmon_tbase_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int PERIOD_W   = 18,
    parameter logic [PERIOD_W-1:0] PERIOD_RST = 18'h1E600
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                mode_auto_o,
    output logic                src_int_o,
    output logic                man_pend_o,
    output logic [PERIOD_W-1:0] period_o
);

    logic sel_ctrl;
    logic sel_period;
    logic unused_wdata_hi;

    assign sel_ctrl        = (addr_i == ADDR_W'(ADDR_CTRL));
    assign sel_period      = (addr_i == ADDR_W'(ADDR_PERIOD));
    assign unused_wdata_hi = ^wdata_i[DATA_W-1:PERIOD_W];

    // Register update: control bits, self-clearing trigger, interval value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_auto_o <= 1'b1;
            src_int_o   <= 1'b1;
            man_pend_o  <= 1'b0;
            period_o    <= PERIOD_RST;
        end else begin
            man_pend_o <= 1'b0;
            if (wr_i && sel_ctrl) begin
                mode_auto_o <= wdata_i[CTRL_MODE_BIT];
                src_int_o   <= wdata_i[CTRL_SRC_BIT];
                man_pend_o  <= wdata_i[CTRL_MAN_BIT];
            end
            if (wr_i && sel_period)
                period_o <= wdata_i[PERIOD_W-1:0];
        end
    end

    // Read multiplexer: unmapped addresses and bits read as zero.
    always_comb begin
        rdata_o = '0;
        if (sel_ctrl) begin
            rdata_o[CTRL_MODE_BIT] = mode_auto_o;
            rdata_o[CTRL_SRC_BIT]  = src_int_o;
            rdata_o[CTRL_MAN_BIT]  = man_pend_o;
        end else if (sel_period) begin
            rdata_o[PERIOD_W-1:0] = period_o;
        end
    end

endmodule

// File: rtl/pmon_interval_timer.sv
// Module: pmon_interval_timer
// A down-counter that flags its terminal count once every max(period,1)
// cycles while enabled. It reloads at the terminal count. While disabled
// it holds at the reload value, so period changes take effect only on a reload.
// Assumes period_i comes straight from a register.
module pmon_interval_timer #(
    parameter int PERIOD_W = 18,
    parameter logic [PERIOD_W-1:0] RST_LOAD = 18'h1E600
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                hit_o,
    output logic [PERIOD_W-1:0] cnt_o,
    output logic [PERIOD_W-1:0] reload_o
);

    localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

    logic at_end;

    // Reload value: zero is promoted to one so the counter never stalls.
    assign reload_o = (period_i == '0) ? ONE : period_i;
    assign at_end   = (cnt_o == ONE);
    assign hit_o    = en_i && at_end;

    // Count down while enabled; reload at the end or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= RST_LOAD;
        else if (!en_i || at_end)
            cnt_o <= reload_o;
        else
            cnt_o <= cnt_o - ONE;
    end

endmodule

// File: rtl/pmon_edge_sync.sv
// Module: pmon_edge_sync
// Brings an asynchronous input into the clock domain through STAGES flops.
// One extra flop is used to detect a rising edge.
// rise_o is high for one cycle for each low-to-high transition seen.
// Assumes the input stays at each level for at least one clock period.
module pmon_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic rise_o
);

    logic [STAGES:0] shreg;

    // Synchronizer chain plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else
            shreg <= {shreg[STAGES-1:0], d_i};
    end

    assign rise_o = shreg[STAGES-1] && !shreg[STAGES];

endmodule

// File: rtl/pmon_timebase.sv
// Module: pmon_timebase (top)
// A timebase tick generator for performance-monitor sampling.
// The tick can come from the internal interval timer, from the external
// timebase input or from the controller pulse input, and a manual trigger
// can be added on top. All causes are ORed into one registered pulse,
// so causes that fall in the same cycle give a single tick.
// Assumes ext_tb_i and obc_pulse_i are asynchronous to clk.
module pmon_timebase
    import pmon_tbase_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int PERIOD_W    = 18,
    parameter logic [PERIOD_W-1:0] PERIOD_RST = 18'h1E600,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr_i,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic [DATA_W-1:0] csr_wdata_i,
    output logic [DATA_W-1:0] csr_rdata_o,
    input  logic              ext_tb_i,
    input  logic              obc_pulse_i,
    output logic              tick_o
);

    localparam int N_EXT = 2;
    localparam int IDX_TB  = 0;
    localparam int IDX_OBC = 1;
    localparam logic [PERIOD_W-1:0] RST_LOAD =
        (PERIOD_RST == '0) ? PERIOD_W'(1) : PERIOD_RST;

    logic                mode_auto;
    logic                src_int;
    logic                man_pend;
    logic [PERIOD_W-1:0] period;
    logic [PERIOD_W-1:0] tmr_cnt;
    logic [PERIOD_W-1:0] eff_period;
    logic                int_en;
    logic                int_hit;
    logic                ext_hit;
    logic [N_EXT-1:0]    ext_raw;
    logic [N_EXT-1:0]    ext_rise;
    tb_src_e             src_sel;

    pmon_tbase_csr #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .PERIOD_W   (PERIOD_W),
        .PERIOD_RST (PERIOD_RST)
    ) u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (csr_wr_i),
        .addr_i      (csr_addr_i),
        .wdata_i     (csr_wdata_i),
        .rdata_o     (csr_rdata_o),
        .mode_auto_o (mode_auto),
        .src_int_o   (src_int),
        .man_pend_o  (man_pend),
        .period_o    (period)
    );

    assign src_sel = decode_src(mode_auto, src_int);
    assign int_en  = (src_sel == SRC_INT_TMR);

    pmon_interval_timer #(
        .PERIOD_W (PERIOD_W),
        .RST_LOAD (RST_LOAD)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (int_en),
        .period_i (period),
        .hit_o    (int_hit),
        .cnt_o    (tmr_cnt),
        .reload_o (eff_period)
    );

    assign ext_raw[IDX_TB]  = ext_tb_i;
    assign ext_raw[IDX_OBC] = obc_pulse_i;

    // One synchronizer and edge detector per external input.
    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        pmon_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_i    (ext_raw[g]),
            .rise_o (ext_rise[g])
        );
    end

    assign ext_hit = ((src_sel == SRC_EXT_TB) && ext_rise[IDX_TB]) ||
                     ((src_sel == SRC_OBC)    && ext_rise[IDX_OBC]);

    // Output pulse: any cause registers as one tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_o <= 1'b0;
        else
            tick_o <= int_hit || ext_hit || man_pend;
    end

endmodule

// File: rtl/pmon_timebase_chk.sv
// Module: pmon_timebase_chk
// Temporal checks on the timebase generator, attached to it through bind.
// Assumes synchronous active-low reset on rst_n.
module pmon_timebase_chk #(
    parameter int PERIOD_W = 18
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_o,
    input logic                int_hit,
    input logic                ext_hit,
    input logic                man_pend,
    input logic                int_en,
    input logic [PERIOD_W-1:0] tmr_cnt,
    input logic [PERIOD_W-1:0] eff_period
);

    // R3: a terminal count of the interval timer produces a tick next cycle.
    p_int_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int_hit |=> tick_o);

    // R4: while not selected, the counter sits at the reload value.
    p_hold_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |=> (tmr_cnt == $past(eff_period)));

    // R5: the counter never reaches zero, even with a zero interval.
    p_cnt_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_cnt != '0);

    // R6: a qualified external edge yields a tick next cycle.
    p_ext_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_hit |=> tick_o);

    // R8: every tick has a cause in the cycle before.
    p_tick_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(int_hit || ext_hit || man_pend));

    // R9: a pending manual trigger yields a tick next cycle.
    p_manual_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        man_pend |=> tick_o);

endmodule

bind pmon_timebase pmon_timebase_chk #(.PERIOD_W(PERIOD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_o     (tick_o),
    .int_hit    (int_hit),
    .ext_hit    (ext_hit),
    .man_pend   (man_pend),
    .int_en     (int_en),
    .tmr_cnt    (tmr_cnt),
    .eff_period (eff_period)
);

// File: tb/pmon_timebase_tb.sv
// Bench for pmon_timebase: a behavioural reference model, compared on every clock.
module pmon_timebase_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr_i = 1'b0;
    logic [7:0]  csr_addr_i = '0;
    logic [31:0] csr_wdata_i = '0;
    logic [31:0] csr_rdata_o;
    logic        ext_tb_i = 1'b0;
    logic        obc_pulse_i = 1'b0;
    logic        tick_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    n_coinc  = 0;
    bit    done     = 1'b0;
    string phase_tag = "R1";

    // Reference model state.
    int m_cnt;
    int m_period;
    int m_eff;
    bit m_mode;
    bit m_src;
    bit m_man;
    bit m_iact;
    bit m_ih;
    bit m_eh;
    bit exp_tick;
    bit tb_hist[3];
    bit obc_hist[3];

    always #10 clk = ~clk;

    pmon_timebase u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .csr_wr_i    (csr_wr_i),
        .csr_addr_i  (csr_addr_i),
        .csr_wdata_i (csr_wdata_i),
        .csr_rdata_o (csr_rdata_o),
        .ext_tb_i    (ext_tb_i),
        .obc_pulse_i (obc_pulse_i),
        .tick_o      (tick_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model: compute the tick due from the pre-edge state, then advance.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 'h1E600; m_period = 'h1E600; m_mode = 1; m_src = 1; m_man = 0;
            exp_tick = 0;
            for (int i = 0; i < 3; i++) begin tb_hist[i] = 0; obc_hist[i] = 0; end
        end else begin
            m_eff  = (m_period == 0) ? 1 : m_period;
            m_iact = m_mode && m_src;
            m_ih   = m_iact && (m_cnt == 1);
            m_eh   = (!m_mode && tb_hist[1] && !tb_hist[2]) ||
                     (m_mode && !m_src && obc_hist[1] && !obc_hist[2]);
            if (m_man && (m_ih || m_eh)) n_coinc++;
            exp_tick = m_ih || m_eh || m_man;
            m_cnt = (!m_iact || m_cnt == 1) ? m_eff : m_cnt - 1;
            tb_hist[2] = tb_hist[1]; tb_hist[1] = tb_hist[0]; tb_hist[0] = ext_tb_i;
            obc_hist[2] = obc_hist[1]; obc_hist[1] = obc_hist[0]; obc_hist[0] = obc_pulse_i;
            m_man = 0;
            if (csr_wr_i && csr_addr_i == 8'd0) begin
                m_mode = csr_wdata_i[0]; m_src = csr_wdata_i[1]; m_man = csr_wdata_i[2];
            end
            if (csr_wr_i && csr_addr_i == 8'd1) m_period = int'(csr_wdata_i[17:0]);
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done)
            chk(tick_o == exp_tick, (m_man && (m_ih || m_eh)) ? "R10" : phase_tag,
                tick_o, exp_tick);
    end

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        csr_wr_i = 1'b1; csr_addr_i = 8'(addr); csr_wdata_i = data;
        @(negedge clk);
        csr_wr_i = 1'b0; csr_wdata_i = '0;
    endtask

    task automatic rd_chk(input int addr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        csr_addr_i = 8'(addr);
        #1;
        chk(csr_rdata_o == exp, tag, csr_rdata_o, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tb(input int len);
        @(negedge clk); ext_tb_i = 1'b1;
        repeat (len) @(negedge clk);
        ext_tb_i = 1'b0;
    endtask

    task automatic pulse_obc(input int len);
        @(negedge clk); obc_pulse_i = 1'b1;
        repeat (len) @(negedge clk);
        obc_pulse_i = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog act=timeout exp=done");
            finish_run();
        end
    end

    initial begin
        // R1: reset state.
        idle(3);
        chk(tick_o == 1'b0, "R1", tick_o, 0);
        rd_chk(0, 32'h3, "R1");
        rd_chk(1, 32'h1E600, "R1");
        @(negedge clk); rst_n = 1'b1;
        #1 chk(tick_o == 1'b0, "R1", tick_o, 0);

        // R2: register map, width masking, unmapped address.
        phase_tag = "R2";
        wr(0, 32'hFFFF_FFF8);
        rd_chk(0, 32'h0, "R2");
        wr(1, 32'hFFFF_FFFF);
        rd_chk(1, 32'h3FFFF, "R2");
        wr(5, 32'hFFFF_FFFF);
        rd_chk(5, 32'h0, "R2");
        rd_chk(0, 32'h0, "R2");
        rd_chk(1, 32'h3FFFF, "R2");

        // R4: counter idles at reload, so a fresh period applies on selection.
        phase_tag = "R4";
        wr(1, 32'd4);
        wr(0, 32'h3);
        phase_tag = "R3";
        idle(20);
        phase_tag = "R4";
        wr(1, 32'd7);
        idle(25);
        wr(1, 32'd4);
        idle(12);

        // R10: manual trigger at four phase offsets against a 4-cycle interval.
        phase_tag = "R9";
        for (int k = 0; k < 4; k++) begin
            idle(k);
            wr(0, 32'h7);
            idle(6);
        end
        chk(n_coinc > 0, "R10", n_coinc, 1);

        // R5: zero interval ticks every cycle.
        phase_tag = "R5";
        wr(1, 32'd0);
        idle(12);

        // R6: external timebase mode, various pulse shapes; R8 obc ignored.
        phase_tag = "R6";
        wr(0, 32'h0);
        idle(4);
        pulse_tb(1); idle(4);
        pulse_tb(9); idle(4);
        for (int k = 0; k < 4; k++) pulse_tb(1);
        idle(4);
        phase_tag = "R8";
        pulse_obc(1); idle(3); pulse_obc(5); idle(5);

        // R7: controller pulse source; R8 timebase input ignored.
        phase_tag = "R7";
        wr(0, 32'h1);
        idle(4);
        pulse_obc(1); idle(4);
        pulse_obc(7); idle(4);
        for (int k = 0; k < 3; k++) pulse_obc(2);
        idle(4);
        phase_tag = "R8";
        pulse_tb(1); idle(3); pulse_tb(6); idle(5);

        // R9: manual trigger in external modes, bit reads back 0 afterwards.
        phase_tag = "R9";
        wr(0, 32'h5);
        idle(2);
        rd_chk(0, 32'h1, "R9");
        wr(0, 32'h4);
        idle(2);
        rd_chk(0, 32'h0, "R9");
        idle(6);

        // R10: manual coinciding with an external edge.
        phase_tag = "R10";
        fork
            pulse_tb(1);
            begin idle(1); wr(0, 32'h4); end
        join
        idle(6);

        finish_run();
    end

endmodule